// File: doc/BRIEF.md
# SD Card Clock Generator

This block derives the clock driven to an SD card from a reference clock, under control of a 16-bit control register. Software sets the divider code and the internal enable. The block then waits a fixed settling time before it raises a read-only stable flag. Only after that flag is set does the card-clock enable let pulses reach the card pin.

The reference clock `clk_i` runs at twice the base clock rate. Every half period of the card clock is therefore a whole number of `clk_i` cycles, and the output comes straight from a register with no combinational gating.

While the high-speed input is low, the block clamps the divide ratio so that the card clock never runs faster than `LIMIT_KHZ`. While it is high, any code may be used. A change to the effective ratio, whether from a new code or from a change of the high-speed input, drops the stable flag and restarts settling. The card clock finishes its current high phase, rests low during settling, and resumes at the new rate once the flag is set again.

Top module: `sdclk_ctrl`

## Requirements
- R1: After reset the register reads 0x0000 and the card clock is low.
- R2: Register layout: bit 0 is the internal enable, bit 2 is the card-clock enable and bits 15:8 are the divider code. These fields read back as written. Bit 1 reads the live stable flag. Writes to bit 1 and to all other bits have no effect, and those other bits read 0.
- R3: The stable flag rises no earlier than `SETTLE_CYC` cycles after the internal enable is set, and no later than `SETTLE_CYC`+2 cycles after it. Clearing the internal enable clears the flag.
- R4: While the stable flag is 0 the card clock stays low, whatever the card-clock enable holds.
- R5: Let L be 0 for divider code 0, and otherwise the index of the highest set bit of the code plus 1. With the high-speed input high, the card clock runs with a period of 2·2^L `clk_i` cycles, so code 0 divides the base by 1, code 1 by 2 and code 0x80 by 256.
- R6: With the high-speed input low, L is raised to at least the smallest value that keeps the rate at or below `LIMIT_KHZ`. With the defaults this is L=2, a period of 8 cycles.
- R7: Clearing the internal enable, for example by writing zero, forces the card clock low within two cycles of the write edge, even in the middle of a high phase.
- R8: A change of the effective ratio clears the stable flag on the following cycle. The card clock then stays low until the flag is set again.
- R9: Clearing the card-clock enable during a high phase lets that phase run to its full length of 2^L cycles. The clock then stays low, so no runt pulse appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock, twice the base clock rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 16 | Register write data |
| rd_data_o | output | 16 | Register read data, including the live stable flag |
| hs_en_i | input | 1 | High-speed enable; lifts the rate ceiling |
| card_clk_o | output | 1 | Card clock output |

## Verification
The bench measures the card clock period for several codes, with and without high-speed mode. A design that decoded the code linearly, or ignored the ceiling, would show a wrong period. It counts card-clock edges during settling, so an enable that bypassed the stable flag would show up as early pulses. It clears the card-clock enable just after a rising edge and measures the high phase, which catches a design that truncates pulses. It also clears the internal enable mid-phase and expects the clock low within two cycles, which catches a design that waits for the phase to end. A divider change during operation must drop the stable flag; a design that retimed on the fly without resettling would fail that check.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  localparam int CODE_W = 8;
  localparam int LOG_W  = $clog2(CODE_W + 1);
  localparam int REG_W  = 16;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic              card_en;
    logic              int_en;
  } ctl_t;
endpackage

// File: rtl/sdclk_ratio.sv
module sdclk_ratio #(
  parameter int CODE_W  = 8,
  parameter int LOG_W   = 4,
  parameter int MIN_LOG = 2
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic              hs_i,
  output logic [LOG_W-1:0]  log_o
);
  logic [LOG_W-1:0] raw;

  always_comb begin
    raw = '0;
    for (int i = 0; i < CODE_W; i++)
      if (code_i[i]) raw = LOG_W'(i + 1);
  end

  // ceiling applies only outside high-speed mode
  assign log_o = (!hs_i && (raw < LOG_W'(MIN_LOG))) ? LOG_W'(MIN_LOG) : raw;
endmodule

// File: rtl/sdclk_settle.sv
module sdclk_settle #(
  parameter int LOG_W      = 4,
  parameter int SETTLE_CYC = 512
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [LOG_W-1:0] cfg_i,
  output logic             stable_o
);
  localparam int SC_W = $clog2(SETTLE_CYC + 1);

  logic [SC_W-1:0]  cnt_q;
  logic [LOG_W-1:0] cfg_q;
  logic             chg;

  assign chg = (cfg_i != cfg_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      stable_o <= 1'b0;
    end else if (!en_i || chg) begin
      cnt_q    <= '0;
      stable_o <= 1'b0;
    end else if (!stable_o) begin
      if (cnt_q == SC_W'(SETTLE_CYC - 1)) stable_o <= 1'b1;
      else                                cnt_q    <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sdclk_div.sv
module sdclk_div #(
  parameter int CODE_W = 8,
  parameter int LOG_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             run_i,
  input  logic [LOG_W-1:0] log_i,
  output logic             ck_o
);
  logic [CODE_W-1:0] cnt_q;
  logic [LOG_W-1:0]  log_q;
  logic [CODE_W:0]   half;
  logic              term;

  assign half = (CODE_W + 1)'(1) << log_q;
  assign term = ({1'b0, cnt_q} == (half - 1'b1));

  // ratio reloads only while parked low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               log_q <= '0;
    else if (!ck_o && !run_i)  log_q <= log_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ck_o  <= 1'b0;
      cnt_q <= '0;
    end else if (!en_i) begin
      ck_o  <= 1'b0;
      cnt_q <= '0;
    end else if (ck_o || run_i) begin
      if (term) begin
        ck_o  <= ~ck_o;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end
endmodule

// File: rtl/sdclk_ctrl.sv
module sdclk_ctrl
  import sdclk_pkg::*;
#(
  parameter int SETTLE_CYC = 512,
  parameter int BASE_KHZ   = 100000,
  parameter int LIMIT_KHZ  = 25000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             hs_en_i,
  output logic             card_clk_o
);
  function automatic int min_log_f(input longint base, input longint lim);
    for (int k = 0; k <= CODE_W; k++)
      if ((lim << k) >= base) return k;
    return CODE_W;
  endfunction

  localparam int MIN_LOG = min_log_f(BASE_KHZ, LIMIT_KHZ);

  ctl_t             ctl_q;
  logic             int_en_q;
  logic             card_en_q;
  logic             stable_w;
  logic [LOG_W-1:0] eff_log_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else if (wr_en_i) begin
      ctl_q.int_en  <= wr_data_i[0];
      ctl_q.card_en <= wr_data_i[2];
      ctl_q.code    <= wr_data_i[REG_W-1 -: CODE_W];
    end
  end

  assign int_en_q  = ctl_q.int_en;
  assign card_en_q = ctl_q.card_en;
  assign rd_data_o = {ctl_q.code, {(REG_W-CODE_W-3){1'b0}}, card_en_q, stable_w, int_en_q};

  sdclk_ratio #(.CODE_W(CODE_W), .LOG_W(LOG_W), .MIN_LOG(MIN_LOG)) i_ratio (
    .code_i (ctl_q.code),
    .hs_i   (hs_en_i),
    .log_o  (eff_log_w)
  );

  sdclk_settle #(.LOG_W(LOG_W), .SETTLE_CYC(SETTLE_CYC)) i_settle (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (int_en_q),
    .cfg_i    (eff_log_w),
    .stable_o (stable_w)
  );

  sdclk_div #(.CODE_W(CODE_W), .LOG_W(LOG_W)) i_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (int_en_q),
    .run_i  (int_en_q && card_en_q && stable_w),
    .log_i  (eff_log_w),
    .ck_o   (card_clk_o)
  );
endmodule

// File: rtl/sdclk_ctrl_chk.sv
module sdclk_ctrl_chk #(
  parameter int LOG_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             card_clk_o,
  input logic [15:0]      rd_data_o,
  input logic             int_en_q,
  input logic             card_en_q,
  input logic             stable_w,
  input logic [LOG_W-1:0] eff_log_w
);
  // R3
  stable_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !int_en_q |=> !stable_w);

  // R3
  stable_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_data_o[1]) |-> $past(rd_data_o[0]));

  // R4
  rise_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(card_clk_o) |-> $past(stable_w && card_en_q && int_en_q));

  // R7
  off_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !int_en_q |=> !card_clk_o);

  // R8
  resettle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eff_log_w != $past(eff_log_w)) |=> !stable_w);
endmodule

bind sdclk_ctrl sdclk_ctrl_chk #(.LOG_W(sdclk_pkg::LOG_W)) i_sdclk_ctrl_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .card_clk_o (card_clk_o),
  .rd_data_o  (rd_data_o),
  .int_en_q   (int_en_q),
  .card_en_q  (card_en_q),
  .stable_w   (stable_w),
  .eff_log_w  (eff_log_w)
);

// File: tb/test_sdclk_ctrl.sv
`timescale 1ns/1ps
module test_sdclk_ctrl;
  localparam int SETTLE = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        hs_en = 1'b1;
  logic        card_clk;

  int checks = 0;
  int errs   = 0;

  always #2 clk = ~clk;

  sdclk_ctrl #(.SETTLE_CYC(SETTLE)) i_sdclk_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .hs_en_i(hs_en), .card_clk_o(card_clk)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // call just after a negedge; returns just after the capturing posedge
  task automatic wr(input logic [15:0] d);
    wr_en = 1'b1; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic wait_stable(input string req);
    bit ok = 0;
    for (int i = 0; i < 2*SETTLE + 8; i++) begin
      @(negedge clk);
      if (rd_data[1]) begin ok = 1; break; end
    end
    chk(req, ok, 1);
  endtask

  task automatic wait_rise(output bit ok);
    bit p0 = card_clk;
    ok = 0;
    for (int i = 0; i < 1200; i++) begin
      @(negedge clk);
      if (!p0 && card_clk) begin ok = 1; return; end
      p0 = card_clk;
    end
  endtask

  task automatic period(output int p);
    bit ok;
    p = 0;
    wait_rise(ok);
    if (!ok) return;
    for (int i = 0; i < 1200; i++) begin
      bit prev = card_clk;
      @(negedge clk);
      p++;
      if (!prev && card_clk) return;
    end
    p = -1;
  endtask

  task automatic t_reset;
    chk("R1 read", rd_data, 16'h0000);
    chk("R1 clk", card_clk, 0);
  endtask

  task automatic t_readback;
    @(negedge clk); wr(16'h80FF);
    @(negedge clk); chk("R2 fields", rd_data, 16'h8005);
    wr(16'h0002);
    @(negedge clk); chk("R2 ignored", rd_data, 16'h0000);
  endtask

  task automatic t_settle;
    int rises = 0;
    bit p0;
    @(negedge clk); wr(16'h0005);
    @(negedge clk);
    p0 = card_clk;
    for (int k = 1; k <= SETTLE - 2; k++) begin
      @(negedge clk);
      if (!p0 && card_clk) rises++;
      p0 = card_clk;
    end
    chk("R3 early", rd_data[1], 0);
    chk("R4 gated", rises, 0);
    wait_stable("R3 rise");
  endtask

  task automatic t_ratio;
    int p;
    period(p); chk("R5 code0", p, 2);
    @(negedge clk); wr(16'h0405);
    repeat (3) @(negedge clk);
    chk("R8 drop", rd_data[1], 0);
    chk("R8 low", card_clk, 0);
    wait_stable("R8 resettle");
    period(p); chk("R5 code4", p, 16);
  endtask

  task automatic t_ceiling;
    int p;
    @(negedge clk); hs_en = 1'b0; wr(16'h0005);
    wait_stable("R6 settle");
    period(p); chk("R6 clamp0", p, 8);
    @(negedge clk); wr(16'h0105);
    wait_stable("R6 settle1");
    period(p); chk("R6 clamp1", p, 8);
    @(negedge clk); hs_en = 1'b1;
    wait_stable("R6 hs");
    period(p); chk("R5 code1", p, 4);
    @(negedge clk); hs_en = 1'b0; wr(16'h8005);
    wait_stable("R6 settle80");
    period(p); chk("R5 code80", p, 512);
  endtask

  task automatic t_gate;
    bit ok;
    int hi = 1;
    int bad = 0;
    @(negedge clk); hs_en = 1'b1; wr(16'h0205);
    wait_stable("R9 settle");
    wait_rise(ok);
    chk("R9 running", ok, 1);
    wr(16'h0201);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (card_clk) hi++; else break;
    end
    chk("R9 full high", hi, 4);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (card_clk) bad++;
    end
    chk("R9 parked", bad, 0);
    chk("R9 read", rd_data, 16'h0203);
  endtask

  task automatic t_off;
    bit ok;
    @(negedge clk); wr(16'h0405);
    wait_rise(ok);
    chk("R7 running", ok, 1);
    wr(16'h0000);
    repeat (2) @(negedge clk);
    chk("R7 low", card_clk, 0);
    chk("R7 read", rd_data, 16'h0000);
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_readback;
    t_settle;
    t_ratio;
    t_ceiling;
    t_gate;
    t_off;
    report;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog: actual=expired expected=done");
    report;
  end
endmodule